// File: doc/BRIEF.md
# Disk Interface Alternate Control Registers

This block is the device-side logic that answers the pair of alternate control addresses on a legacy AT-style disk cable. The host programs a control byte at the lower address (3F6h). From that byte the block keeps two bits in flops: a software reset request and an active-low interrupt enable. The reset request goes straight out to the rest of the device as a reset. The interrupt enable, together with the drive-select state, decides whether the device's interrupt pin is driven at all.

At the upper address (3F7h) the host reads a status byte. The block builds this byte every cycle from live inputs. It holds an active-low write gate, the one's complement of the selected head number, and two active-low drive-select flags. The top bit is never driven: a per-bit output-enable vector releases that line even while the other seven bits are on the bus.

The device that owns this logic can be either drive on the cable. A software reset applies whatever the selected drive is. Interrupt driving applies only while this device is the one selected.

Top module: `ata_ctl_regs`

## Requirements
- R1: During a read (read strobe low, control chip select low, address 3F7h), `host_rd_oe` is 8'h7F: bits 6..0 are driven and bit 7 is released.
- R2: In the status byte, bit 6 reads 0 while `wr_busy` is 1, and reads 1 otherwise.
- R3: In the status byte, bits 5..2 read the bitwise inverse of `head_sel`, with bit 5 as the most significant (head 3 reads 1100b).
- R4: In the status byte, bit 0 reads 0 only when drive 0 is selected (`drive_sel`=0) and no software reset is in force. Bit 1 reads 0 only when drive 1 is selected and no software reset is in force. Otherwise each of these bits reads 1.
- R5: A write to 3F6h with data bit 2 set raises `srst_out` at the next clock edge. It stays high until a write to 3F6h with bit 2 clear, which lowers it at the next edge.
- R6: The software reset takes effect for every combination of `drive_sel` and `dev_is_slave`.
- R7: Data bit 1 of a write to 3F6h is latched as an active-low interrupt enable. A write with bit 2 set leaves interrupts disabled, whatever bit 1 holds.
- R8: `irq_oe` is 1 only when interrupts are enabled and `drive_sel` equals `dev_is_slave`. `irq_out` equals `core_irq` while `irq_oe` is 1, and is 0 otherwise.
- R9: Data bits 7..3 and bit 0 of a write to 3F6h have no effect on any output.
- R10: After a hardware reset, `srst_out` is 0 and interrupts are disabled.
- R11: Outside a read, `host_rd_oe` and `host_rdata` are zero. A write to 3F7h, a write with the chip select high, or a write with the write strobe high leaves the control state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| host_addr | input | 10 | Host register address |
| host_cs_n | input | 1 | Control-block chip select, active low |
| host_rd_n | input | 1 | Read strobe, active low |
| host_wr_n | input | 1 | Write strobe, active low |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data toward the host |
| host_rd_oe | output | 8 | Per-bit drive enable for `host_rdata` |
| head_sel | input | 4 | Currently selected head number |
| drive_sel | input | 1 | Drive selected on the cable (0 or 1) |
| dev_is_slave | input | 1 | Identity of this device (0 = drive 0, 1 = drive 1) |
| wr_busy | input | 1 | A media write is in progress |
| core_irq | input | 1 | Interrupt request from the device core |
| srst_out | output | 1 | Software reset toward the device core |
| irq_out | output | 1 | Host interrupt value |
| irq_oe | output | 1 | Host interrupt drive enable |

## Verification
Read results are combinational, so a status byte is due in the same cycle as the read strobe. The bench drives inputs at a falling edge and samples one time unit later, before any rising edge. Control writes land at the rising edge that ends the strobe cycle. The bench therefore samples `srst_out`, `irq_oe` and `irq_out` at the next falling edge, after the write strobe has been released. The bench sweeps all head, write-busy and drive-select combinations, both with and without soft reset. It also sweeps all 256 control-byte values against all four select/identity pairs.

// File: rtl/ata_ctl_pkg.sv
// Package: bit positions and the status byte layout shared by the
// alternate control register logic. Assumes an 8-bit host data path.
package ata_ctl_pkg;

    localparam int DATA_W     = 8;
    localparam int HEAD_W     = 4;
    localparam int SRST_POS   = 2;
    localparam int NIEN_POS   = 1;

    // Status byte read at the drive address location, MSB first.
    typedef struct packed {
        logic              released;
        logic              wgate_n;
        logic [HEAD_W-1:0] head_n;
        logic              ds1_n;
        logic              ds0_n;
    } drv_status_t;

endpackage

// File: rtl/ata_ctl_decode.sv
// Module: host access decoder. Turns the host address, chip select and
// strobes into a control-register write hit and a status read hit.
// Assumes strobes and chip select are synchronous to clk, all active low.
module ata_ctl_decode #(
    parameter int               ADDR_W      = 10,
    parameter logic [ADDR_W-1:0] DEVCTL_ADDR = 10'h3F6,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 10'h3F7
) (
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_cs_n,
    input  logic              host_rd_n,
    input  logic              host_wr_n,
    output logic              ctl_wr_hit,
    output logic              sts_rd_hit
);

    // Qualify each strobe with the chip select and its own address.
    always_comb begin
        ctl_wr_hit = !host_cs_n && !host_wr_n && (host_addr == DEVCTL_ADDR);
        sts_rd_hit = !host_cs_n && !host_rd_n && (host_addr == STATUS_ADDR);
    end

endmodule

// File: rtl/ata_ctl_devctl.sv
// Module: device control latch. Holds the software reset request and the
// active-low interrupt enable. A reset request also forces interrupts off.
// Assumes synchronous active-low hardware reset.
module ata_ctl_devctl (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_hit,
    input  logic wr_srst,
    input  logic wr_nien,
    output logic srst_q,
    output logic nien_q
);

    // Latch both control bits on a qualified host write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            srst_q <= 1'b0;
            nien_q <= 1'b1;
        end else if (wr_hit) begin
            srst_q <= wr_srst;
            nien_q <= wr_nien | wr_srst;
        end
    end

endmodule

// File: rtl/ata_ctl_status.sv
// Module: status byte composer. Builds the drive address byte from live
// state and produces the per-bit output enable for the host data bus.
// Assumes the read hit is already qualified; the top bit is never driven.
module ata_ctl_status
    import ata_ctl_pkg::*;
(
    input  logic              rd_hit,
    input  logic [HEAD_W-1:0] head_sel,
    input  logic              drive_sel,
    input  logic              in_reset,
    input  logic              wr_busy,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] rd_oe
);

    drv_status_t word;
    logic        active;

    // Compose the inverted fields of the status byte.
    always_comb begin
        active        = !in_reset;
        word.released = 1'b0;
        word.wgate_n  = !wr_busy;
        word.head_n   = ~head_sel;
        word.ds1_n    = !(drive_sel && active);
        word.ds0_n    = !(!drive_sel && active);
    end

    // Gate data and enables with the read hit; the top line stays released.
    generate
        for (genvar b = 0; b < DATA_W; b++) begin : g_bit
            if (b == DATA_W - 1) begin : g_hiz
                assign rdata[b] = 1'b0;
                assign rd_oe[b] = 1'b0;
            end else begin : g_drv
                assign rdata[b] = rd_hit & word[b];
                assign rd_oe[b] = rd_hit;
            end
        end
    endgenerate

endmodule

// File: rtl/ata_ctl_irqgate.sv
// Module: interrupt output gate. Drives the host interrupt only when the
// latched enable is active and this device is the selected drive.
module ata_ctl_irqgate (
    input  logic nien_q,
    input  logic drive_sel,
    input  logic dev_is_slave,
    input  logic core_irq,
    output logic irq_out,
    output logic irq_oe
);

    // Enable follows selection match and the active-low enable bit.
    always_comb begin
        irq_oe  = !nien_q && (drive_sel == dev_is_slave);
        irq_out = irq_oe & core_irq;
    end

endmodule

// File: rtl/ata_ctl_regs.sv
// Module: top of the alternate control register logic. Decodes host
// accesses, holds the control bits, composes the status byte and gates
// the interrupt. Assumes one clock domain and synchronous active-low reset.
module ata_ctl_regs
    import ata_ctl_pkg::*;
#(
    parameter int               ADDR_W      = 10,
    parameter logic [ADDR_W-1:0] DEVCTL_ADDR = 10'h3F6,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 10'h3F7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_cs_n,
    input  logic              host_rd_n,
    input  logic              host_wr_n,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    output logic [7:0]        host_rd_oe,
    input  logic [3:0]        head_sel,
    input  logic              drive_sel,
    input  logic              dev_is_slave,
    input  logic              wr_busy,
    input  logic              core_irq,
    output logic              srst_out,
    output logic              irq_out,
    output logic              irq_oe
);

    logic ctl_wr_hit;
    logic sts_rd_hit;
    logic srst_q;
    logic nien_q;
    logic unused_wdata;

    // Collect the write bits that carry no meaning.
    assign unused_wdata = ^{host_wdata[7:SRST_POS+1], host_wdata[0]};

    ata_ctl_decode #(
        .ADDR_W      (ADDR_W),
        .DEVCTL_ADDR (DEVCTL_ADDR),
        .STATUS_ADDR (STATUS_ADDR)
    ) u_decode (
        .host_addr  (host_addr),
        .host_cs_n  (host_cs_n),
        .host_rd_n  (host_rd_n),
        .host_wr_n  (host_wr_n),
        .ctl_wr_hit (ctl_wr_hit),
        .sts_rd_hit (sts_rd_hit)
    );

    ata_ctl_devctl u_devctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hit  (ctl_wr_hit),
        .wr_srst (host_wdata[SRST_POS]),
        .wr_nien (host_wdata[NIEN_POS]),
        .srst_q  (srst_q),
        .nien_q  (nien_q)
    );

    ata_ctl_status u_status (
        .rd_hit    (sts_rd_hit),
        .head_sel  (head_sel),
        .drive_sel (drive_sel),
        .in_reset  (srst_q),
        .wr_busy   (wr_busy),
        .rdata     (host_rdata),
        .rd_oe     (host_rd_oe)
    );

    ata_ctl_irqgate u_irqgate (
        .nien_q       (nien_q),
        .drive_sel    (drive_sel),
        .dev_is_slave (dev_is_slave),
        .core_irq     (core_irq),
        .irq_out      (irq_out),
        .irq_oe       (irq_oe)
    );

    // Reset toward the core is the latched request, for either drive.
    assign srst_out = srst_q;

endmodule

// File: rtl/ata_ctl_regs_chk.sv
// Module: port-level property checker for ata_ctl_regs, bound to it below.
module ata_ctl_regs_chk #(
    parameter int               ADDR_W      = 10,
    parameter logic [ADDR_W-1:0] DEVCTL_ADDR = 10'h3F6,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 10'h3F7
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] host_addr,
    input logic              host_cs_n,
    input logic              host_rd_n,
    input logic              host_wr_n,
    input logic [7:0]        host_wdata,
    input logic [7:0]        host_rdata,
    input logic [7:0]        host_rd_oe,
    input logic [3:0]        head_sel,
    input logic              drive_sel,
    input logic              dev_is_slave,
    input logic              wr_busy,
    input logic              core_irq,
    input logic              srst_out,
    input logic              irq_out,
    input logic              irq_oe
);

    logic rd_req;
    logic wr_req;
    assign rd_req = !host_cs_n && !host_rd_n && (host_addr == STATUS_ADDR);
    assign wr_req = !host_cs_n && !host_wr_n && (host_addr == DEVCTL_ADDR);

    p_read_oe_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> host_rd_oe == 8'h7F);
    p_wgate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> host_rdata[6] == !wr_busy);
    p_head_inv_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> host_rdata[5:2] == ~head_sel);
    p_sel_in_reset_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && srst_out) |-> host_rdata[1:0] == 2'b11);
    p_srst_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |=> srst_out == $past(host_wdata[2]));
    p_srst_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_req |=> $stable(srst_out));
    p_reset_masks_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        srst_out |-> !irq_oe);
    p_irq_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_oe |-> drive_sel == dev_is_slave);
    p_irq_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_oe |-> !irq_out);
    p_bus_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |-> (host_rd_oe == 8'h00 && host_rdata == 8'h00));

endmodule

bind ata_ctl_regs ata_ctl_regs_chk #(
    .ADDR_W      (ADDR_W),
    .DEVCTL_ADDR (DEVCTL_ADDR),
    .STATUS_ADDR (STATUS_ADDR)
) u_chk (.*);

// File: tb/ata_ctl_regs_bench.sv
module ata_ctl_regs_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [9:0] host_addr;
    logic       host_cs_n, host_rd_n, host_wr_n;
    logic [7:0] host_wdata;
    logic [7:0] host_rdata, host_rd_oe;
    logic [3:0] head_sel;
    logic       drive_sel, dev_is_slave, wr_busy, core_irq;
    logic       srst_out, irq_out, irq_oe;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ata_ctl_regs u_ata_ctl_regs (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle_bus();
        host_cs_n = 1'b1; host_rd_n = 1'b1; host_wr_n = 1'b1;
        host_addr = 10'h000; host_wdata = 8'h00;
    endtask

    // One write cycle; returns at the falling edge after the latching edge.
    task automatic host_write(input logic [9:0] a, input logic cs_n,
                              input logic wr_n, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_cs_n = cs_n; host_wr_n = wr_n; host_wdata = d;
        @(negedge clk);
        idle_bus();
    endtask

    // Drive a read request and sample one time unit later.
    task automatic host_read(input logic [9:0] a, input logic cs_n);
        @(negedge clk);
        host_addr = a; host_cs_n = cs_n; host_rd_n = 1'b0;
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; total++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; idle_bus();
        head_sel = 4'd0; drive_sel = 1'b0; dev_is_slave = 1'b0;
        wr_busy = 1'b0; core_irq = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R10: reset state, interrupt disabled even though selected
        chk("R10 srst", srst_out, 0);
        chk("R10 irq_oe", irq_oe, 0);
        chk("R10 irq_out", irq_out, 0);
        chk("R11 idle oe", host_rd_oe, 0);

        // R1 R2 R3 R4: full status sweep with and without software reset
        for (int s = 0; s < 2; s++) begin
            host_write(10'h3F6, 1'b0, 1'b0, s[0] ? 8'h0C : 8'h08);
            for (int v = 0; v < 64; v++) begin
                head_sel = v[3:0]; wr_busy = v[4]; drive_sel = v[5];
                host_read(10'h3F7, 1'b0);
                chk("R1 oe", host_rd_oe, 8'h7F);
                chk("R1 bit7", host_rdata[7], 0);
                chk("R2 wgate", host_rdata[6], !v[4]);
                chk("R3 head", host_rdata[5:2], 4'hF - v[3:0]);
                chk("R4 ds1", host_rdata[1], (s == 0 && v[5] == 1) ? 0 : 1);
                chk("R4 ds0", host_rdata[0], (s == 0 && v[5] == 0) ? 0 : 1);
                idle_bus();
            end
        end
        head_sel = 4'd3; wr_busy = 1'b0;
        host_read(10'h3F7, 1'b0);
        chk("R3 head3", host_rdata[5:2], 4'b1100);
        idle_bus();

        // R5 R6 R7 R8 R9: every control byte against every select pair
        for (int d = 0; d < 256; d++) begin
            host_write(10'h3F6, 1'b0, 1'b0, d[7:0]);
            for (int p = 0; p < 4; p++) begin
                drive_sel = p[0]; dev_is_slave = p[1]; core_irq = 1'b1;
                #1;
                chk("R5 R6 R9 srst", srst_out, d[2]);
                chk("R7 R8 R9 irq_oe", irq_oe,
                    (!d[2] && !d[1] && (p[0] == p[1])) ? 1 : 0);
                chk("R8 irq_out", irq_out,
                    (!d[2] && !d[1] && (p[0] == p[1])) ? 1 : 0);
                core_irq = 1'b0;
                #1;
                chk("R8 irq_low", irq_out, 0);
            end
        end

        // R5: reset holds until cleared; clearing write releases it
        host_write(10'h3F6, 1'b0, 1'b0, 8'h04);
        repeat (4) @(negedge clk);
        chk("R5 hold", srst_out, 1);
        host_write(10'h3F6, 1'b0, 1'b0, 8'h00);
        chk("R5 release", srst_out, 0);

        // R11: ignored writes leave the state alone
        drive_sel = 1'b1; dev_is_slave = 1'b1; core_irq = 1'b1;
        host_write(10'h3F7, 1'b0, 1'b0, 8'h06);
        chk("R11 wr 3F7 srst", srst_out, 0);
        chk("R11 wr 3F7 irq", irq_oe, 1);
        host_write(10'h3F6, 1'b1, 1'b0, 8'h06);
        chk("R11 cs high", srst_out, 0);
        host_write(10'h3F6, 1'b0, 1'b1, 8'h06);
        chk("R11 wr_n high", irq_oe, 1);

        // R11: no bus drive without a qualified read
        host_read(10'h3F6, 1'b0);
        chk("R11 rd 3F6", host_rd_oe, 0);
        idle_bus();
        host_read(10'h3F7, 1'b1);
        chk("R11 rd cs high", host_rd_oe, 0);
        chk("R11 rd cs data", host_rdata, 0);
        idle_bus();

        // R10: hardware reset returns to released reset and disabled irq
        host_write(10'h3F6, 1'b0, 1'b0, 8'h04);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        #1;
        chk("R10 rerst srst", srst_out, 0);
        chk("R10 rerst irq", irq_oe, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule